// File: doc/BRIEF.md
# Privileged Control Register Access Unit

This unit carries out the read and write operations that a processor core issues against its control registers. The registers fall into three banks: ancillary state, privileged and hyperprivileged. The decoder hands the unit four things: a bank select, a direction bit, a 5-bit register number and two source operands. The second operand is either a register value or a sign-extended 13-bit immediate. One cycle later the unit answers with read data or a fault code. If there is no fault and the operation is a write, the target register is updated on the same edge.

Each register has its own access gate. A register may need the privileged mode, the hyperprivileged mode, a non-zero trap level, or floating point enabled. Some registers are gated only when a trap-control bit in the register is set. The unit keeps the trap-level-indexed trap registers as small per-level stacks. It clamps writes to the trap level and the global level against a ceiling, and the ceiling depends on the current mode. The tick and system tick counters live outside the unit. Writes to them go out on a sideband port, and their current values come in on input ports.

Top module: `ctlreg_unit`

## Requirements
- R1: The value written to any register is `src_a ^ opnd`, where `opnd` is `src_b` when `imm_sel`=0 and the sign extension of `imm13` to 64 bits when `imm_sel`=1.
- R2: Privileged-bank accesses (`op_bank`=1) and gated ancillary registers (performance control 0x10, softint group 0x14 to 0x17, compare 0x19) succeed only when state bit 2 (privileged) or hyper-state bit 2 (hyperprivileged) is 1. Otherwise they return fault code 2, privileged action.
- R3: Hyperprivileged-bank accesses (`op_bank`=2) succeed only when hyper-state bit 2 is 1. Otherwise they return fault code 2. The privileged bit alone does not grant access.
- R4: Any access to trap PC (privileged 0), trap next-PC (1), trap state (2), trap type (3) or hyper trap state (hyperprivileged 1) while the trap level is 0 returns fault code 1, illegal instruction.
- R5: Unassigned numbers return fault code 1. These are: privileged 0x0F and 0x11 to 0x1F; ancillary 0x01, 0x07 to 0x0E, 0x12, 0x1A to 0x1F; ancillary reads of 0x14 and 0x15; ancillary writes of 0x04 and 0x05; hyperprivileged 0x02, 0x04 and 0x07 to 0x1E; writes to the version register (hyperprivileged 0x06); and bank 3.
- R6: A write to trap level (privileged 7) stores min(value, MAX_PTL) when privileged but not hyperprivileged, and min(value, MAX_TL) otherwise. Global level (privileged 0x10) is clamped the same way with MAX_PGL and MAX_GL.
- R7: The graphics status register (ancillary 0x13) is accessible only when FP-state bit 2 (ancillary 6) and state bit 4 (privileged 6) are both 1. Otherwise the access returns fault code 3, FP disabled.
- R8: A write to ancillary 0x0F returns fault code 4, software reset, and updates nothing. A read of ancillary 0x0F is a barrier: it returns 0 with no fault.
- R9: The read-only version register (hyperprivileged 6) returns NWIN in bits 7:0, MAX_TL in bits 15:8 and MAX_GL in bits 23:16.
- R10: The trap registers and hyper trap state keep one entry per trap level. An access at trap level L uses entry L-1.
- R11: An operation that faults changes no register and does not pulse the counter write port.
- R12: A read of the PC (ancillary 5) returns `pc_in[31:0]` zero-extended when state bit 3 (address mask) is 1, and the full `pc_in` otherwise.
- R13: `rsp_valid` follows `op_valid` by exactly one cycle. `rsp_data` is 0 for writes and for faulting operations. With no operation, `rsp_valid` and `rsp_fault` are 0.
- R14: Counter operations use the sideband. A privileged-bank 4 write (hyperprivileged only, else fault 2) and an ancillary 0x18 write (hyperprivileged only, else fault 1) pulse `cnt_wr_en`, with `cnt_wr_stick` = 0 and 1 respectively. Reads return `tick_val` or `stick_val`. A non-privileged ancillary read of 4 or 0x18 returns fault 2 when bit 63 of the counter value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_bank | input | 2 | 0 ancillary, 1 privileged, 2 hyperprivileged, 3 reserved |
| op_regno | input | 5 | Register number within the bank |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand (register form) |
| imm_sel | input | 1 | Use the immediate as second operand |
| imm13 | input | 13 | Signed immediate |
| pc_in | input | 64 | PC of the operation |
| tick_val | input | 64 | Current tick counter value |
| stick_val | input | 64 | Current system tick counter value |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Read result |
| rsp_fault | output | 3 | 0 none, 1 illegal, 2 privileged action, 3 FP disabled, 4 software reset |
| cnt_wr_en | output | 1 | Counter write strobe |
| cnt_wr_stick | output | 1 | 0 tick counter, 1 system tick counter |
| cnt_wr_data | output | 64 | Counter write value |

## Verification
Four properties are checked on every cycle: trap level and global level never exceed their ceilings, the response follows the request by one cycle, a faulted response never comes with a counter strobe, and the trap stack is never written at level 0. Two conditional properties are also checked on every cycle. A hyperprivileged-bank access without the hyperprivileged bit always faults. A successful trap level write in privileged-only mode lands at or below MAX_PTL. The exact stored values need directed sequences of writes followed by read-back. This covers the XOR-with-immediate results, which entry of the trap stack a level selects, the mode-dependent clamp values, blocked writes leaving old contents, and the address-masked PC.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {BK_ANC = 2'd0, BK_PRV = 2'd1, BK_HYP = 2'd2, BK_RSV = 2'd3} bank_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0, FLT_ILLEGAL = 3'd1, FLT_PRIV = 3'd2, FLT_FPOFF = 3'd3, FLT_SWRESET = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    GT_OPEN, GT_PRIV, GT_PRIV_NPT, GT_PRIV_PCR, GT_HPRIV, GT_FPU, GT_HPRIV_ILL, GT_SWRESET
  } gate_e;

  // flat storage targets first (0 .. N_FLAT-1), then computed/forwarded ones
  typedef enum logic [5:0] {
    TG_Y, TG_CCR, TG_ASI, TG_FPRS, TG_PCR, TG_PIC, TG_GSR, TG_SOFTINT, TG_TICKCMP,
    TG_STICKCMP, TG_TBA, TG_PSTATE, TG_TL, TG_PIL, TG_CWP, TG_CANSAVE, TG_CANRESTORE,
    TG_CLEANWIN, TG_OTHERWIN, TG_WSTATE, TG_GL, TG_HPSTATE, TG_HINTP, TG_HTBA, TG_HSTICKCMP,
    TG_SINT_SET, TG_SINT_CLR, TG_HVER, TG_PC, TG_TICK, TG_STICK,
    TG_TPC, TG_TNPC, TG_TSTATE, TG_TT, TG_HTSTATE, TG_NONE
  } target_e;

  localparam int N_FLAT = 25;

  typedef struct packed {
    logic    legal;
    gate_e   gate;
    logic    need_tl;
    target_e tgt;
  } access_t;

  function automatic access_t mk(input gate_e g, input logic ntl, input target_e t);
    access_t r;
    r.legal = 1'b1; r.gate = g; r.need_tl = ntl; r.tgt = t;
    return r;
  endfunction

  function automatic access_t decode_access(input bank_e bank, input logic wr, input logic [4:0] rn);
    access_t r;
    r.legal = 1'b0; r.gate = GT_OPEN; r.need_tl = 1'b0; r.tgt = TG_NONE;
    case (bank)
      BK_ANC: case (rn)
        5'h00: r = mk(GT_OPEN, 1'b0, TG_Y);
        5'h02: r = mk(GT_OPEN, 1'b0, TG_CCR);
        5'h03: r = mk(GT_OPEN, 1'b0, TG_ASI);
        5'h04: if (!wr) r = mk(GT_PRIV_NPT, 1'b0, TG_TICK);
        5'h05: if (!wr) r = mk(GT_OPEN, 1'b0, TG_PC);
        5'h06: r = mk(GT_OPEN, 1'b0, TG_FPRS);
        5'h0F: r = wr ? mk(GT_SWRESET, 1'b0, TG_NONE) : mk(GT_OPEN, 1'b0, TG_NONE);
        5'h10: r = mk(GT_PRIV, 1'b0, TG_PCR);
        5'h11: r = mk(GT_PRIV_PCR, 1'b0, TG_PIC);
        5'h13: r = mk(GT_FPU, 1'b0, TG_GSR);
        5'h14: if (wr) r = mk(GT_PRIV, 1'b0, TG_SINT_SET);
        5'h15: if (wr) r = mk(GT_PRIV, 1'b0, TG_SINT_CLR);
        5'h16: r = mk(GT_PRIV, 1'b0, TG_SOFTINT);
        5'h17: r = mk(GT_PRIV, 1'b0, TG_TICKCMP);
        5'h18: r = wr ? mk(GT_HPRIV_ILL, 1'b0, TG_STICK) : mk(GT_PRIV_NPT, 1'b0, TG_STICK);
        5'h19: r = mk(GT_PRIV, 1'b0, TG_STICKCMP);
        default: ;
      endcase
      BK_PRV: case (rn)
        5'h00: r = mk(GT_PRIV, 1'b1, TG_TPC);
        5'h01: r = mk(GT_PRIV, 1'b1, TG_TNPC);
        5'h02: r = mk(GT_PRIV, 1'b1, TG_TSTATE);
        5'h03: r = mk(GT_PRIV, 1'b1, TG_TT);
        5'h04: r = mk(wr ? GT_HPRIV : GT_PRIV, 1'b0, TG_TICK);
        5'h05: r = mk(GT_PRIV, 1'b0, TG_TBA);
        5'h06: r = mk(GT_PRIV, 1'b0, TG_PSTATE);
        5'h07: r = mk(GT_PRIV, 1'b0, TG_TL);
        5'h08: r = mk(GT_PRIV, 1'b0, TG_PIL);
        5'h09: r = mk(GT_PRIV, 1'b0, TG_CWP);
        5'h0A: r = mk(GT_PRIV, 1'b0, TG_CANSAVE);
        5'h0B: r = mk(GT_PRIV, 1'b0, TG_CANRESTORE);
        5'h0C: r = mk(GT_PRIV, 1'b0, TG_CLEANWIN);
        5'h0D: r = mk(GT_PRIV, 1'b0, TG_OTHERWIN);
        5'h0E: r = mk(GT_PRIV, 1'b0, TG_WSTATE);
        5'h10: r = mk(GT_PRIV, 1'b0, TG_GL);
        default: ;
      endcase
      BK_HYP: case (rn)
        5'h00: r = mk(GT_HPRIV, 1'b0, TG_HPSTATE);
        5'h01: r = mk(GT_HPRIV, 1'b1, TG_HTSTATE);
        5'h03: r = mk(GT_HPRIV, 1'b0, TG_HINTP);
        5'h05: r = mk(GT_HPRIV, 1'b0, TG_HTBA);
        5'h06: if (!wr) r = mk(GT_HPRIV, 1'b0, TG_HVER);
        5'h1F: r = mk(GT_HPRIV, 1'b0, TG_HSTICKCMP);
        default: ;
      endcase
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] combine_operands(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                                       input logic isel, input logic [12:0] imm);
    logic [XLEN-1:0] second;
    second = isel ? {{(XLEN-13){imm[12]}}, imm} : b;
    return a ^ second;
  endfunction

  function automatic logic [XLEN-1:0] clamp_level(input logic [XLEN-1:0] v, input logic [XLEN-1:0] cap);
    return (v > cap) ? cap : v;
  endfunction
endpackage

// File: rtl/ctlreg_gate.sv
module ctlreg_gate
  import ctlreg_pkg::*;
(
  input  access_t acc,
  input  logic    in_priv,
  input  logic    in_hpriv,
  input  logic    fp_ok,
  input  logic    tl_zero,
  input  logic    npt_bit,
  input  logic    pcr_gate,
  output fault_e  fault
);
  always_comb begin
    fault = FLT_NONE;
    if (!acc.legal) begin
      fault = FLT_ILLEGAL;
    end else begin
      case (acc.gate)
        GT_PRIV:      if (!in_priv) fault = FLT_PRIV;
        GT_PRIV_NPT:  if (npt_bit && !in_priv) fault = FLT_PRIV;
        GT_PRIV_PCR:  if (pcr_gate && !in_priv) fault = FLT_PRIV;
        GT_HPRIV:     if (!in_hpriv) fault = FLT_PRIV;
        GT_FPU:       if (!fp_ok) fault = FLT_FPOFF;
        GT_HPRIV_ILL: if (!in_hpriv) fault = FLT_ILLEGAL;
        GT_SWRESET:   fault = FLT_SWRESET;
        default: ;
      endcase
      if (fault == FLT_NONE && acc.need_tl && tl_zero) fault = FLT_ILLEGAL;
    end
  end
endmodule

// File: rtl/ctlreg_trapstack.sv
module ctlreg_trapstack
  import ctlreg_pkg::*;
#(
  parameter int MAX_TL = 6,
  localparam int TLW = $clog2(MAX_TL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  target_e         wr_kind,
  input  logic [TLW-1:0]  level,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_tpc,
  output logic [XLEN-1:0] rd_tnpc,
  output logic [XLEN-1:0] rd_tstate,
  output logic [XLEN-1:0] rd_tt,
  output logic [XLEN-1:0] rd_htstate
);
  logic [XLEN-1:0] tpc_q [MAX_TL];
  logic [XLEN-1:0] tnpc_q [MAX_TL];
  logic [XLEN-1:0] tstate_q [MAX_TL];
  logic [XLEN-1:0] tt_q [MAX_TL];
  logic [XLEN-1:0] htstate_q [MAX_TL];

  for (genvar e = 0; e < MAX_TL; e++) begin : g_level
    logic hit;
    assign hit = wr_en && (level == TLW'(e + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tpc_q[e] <= '0; tnpc_q[e] <= '0; tstate_q[e] <= '0; tt_q[e] <= '0; htstate_q[e] <= '0;
      end else if (hit) begin
        case (wr_kind)
          TG_TPC:     tpc_q[e] <= wr_data;
          TG_TNPC:    tnpc_q[e] <= wr_data;
          TG_TSTATE:  tstate_q[e] <= wr_data;
          TG_TT:      tt_q[e] <= wr_data;
          TG_HTSTATE: htstate_q[e] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  logic [TLW-1:0] rd_idx;
  logic           rd_ok;
  assign rd_ok  = (level != '0) && (level <= TLW'(MAX_TL));
  assign rd_idx = level - TLW'(1);
  assign rd_tpc     = rd_ok ? tpc_q[rd_idx] : '0;
  assign rd_tnpc    = rd_ok ? tnpc_q[rd_idx] : '0;
  assign rd_tstate  = rd_ok ? tstate_q[rd_idx] : '0;
  assign rd_tt      = rd_ok ? tt_q[rd_idx] : '0;
  assign rd_htstate = rd_ok ? htstate_q[rd_idx] : '0;

  // R4
  trap_write_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (level != '0 && level <= TLW'(MAX_TL)));
endmodule

// File: rtl/ctlreg_unit.sv
module ctlreg_unit
  import ctlreg_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3,
  parameter int MAX_PGL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic            op_write,
  input  logic [1:0]      op_bank,
  input  logic [4:0]      op_regno,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            imm_sel,
  input  logic [12:0]     imm13,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] tick_val,
  input  logic [XLEN-1:0] stick_val,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_data,
  output logic [2:0]      rsp_fault,
  output logic            cnt_wr_en,
  output logic            cnt_wr_stick,
  output logic [XLEN-1:0] cnt_wr_data
);
  localparam int TLW = $clog2(MAX_TL + 1);
  localparam logic [XLEN-1:0] HPSTATE_RST = XLEN'(4);
  localparam logic [XLEN-1:0] VERSION = XLEN'(NWIN) | (XLEN'(MAX_TL) << 8) | (XLEN'(MAX_GL) << 16);

  logic [XLEN-1:0] regs_q [N_FLAT];

  // named mode and event wires
  logic [XLEN-1:0] pstate, hpstate;
  logic            priv_mode, hpriv_mode, priv_only, fp_ok, tl_zero, npt_bit;
  logic [TLW-1:0]  tl_now;
  access_t         acc;
  fault_e          fault_c;
  logic [XLEN-1:0] wr_val;
  logic            commit, trap_we, cnt_commit;

  assign pstate     = regs_q[TG_PSTATE];
  assign hpstate    = regs_q[TG_HPSTATE];
  assign priv_mode  = pstate[2] | hpstate[2];
  assign hpriv_mode = hpstate[2];
  assign priv_only  = pstate[2] & ~hpstate[2];
  assign fp_ok      = regs_q[TG_FPRS][2] & pstate[4];
  assign tl_now     = regs_q[TG_TL][TLW-1:0];
  assign tl_zero    = (tl_now == '0);
  assign acc        = decode_access(bank_e'(op_bank), op_write, op_regno);
  assign npt_bit    = (acc.tgt == TG_STICK) ? stick_val[XLEN-1] : tick_val[XLEN-1];
  assign wr_val     = combine_operands(src_a, src_b, imm_sel, imm13);

  ctlreg_gate u_gate (
    .acc(acc), .in_priv(priv_mode), .in_hpriv(hpriv_mode), .fp_ok(fp_ok),
    .tl_zero(tl_zero), .npt_bit(npt_bit), .pcr_gate(regs_q[TG_PCR][0]), .fault(fault_c)
  );

  assign commit     = op_valid && op_write && (fault_c == FLT_NONE);
  assign trap_we    = commit && (acc.tgt inside {TG_TPC, TG_TNPC, TG_TSTATE, TG_TT, TG_HTSTATE});
  assign cnt_commit = commit && (acc.tgt inside {TG_TICK, TG_STICK});

  // flat register update path
  logic [4:0]      flat_idx;
  logic [XLEN-1:0] flat_val;
  logic            flat_we;
  always_comb begin
    flat_idx = acc.tgt[4:0];
    flat_val = wr_val;
    flat_we  = commit && (int'(acc.tgt) < N_FLAT);
    case (acc.tgt)
      TG_TL: flat_val = clamp_level(wr_val, priv_only ? XLEN'(MAX_PTL) : XLEN'(MAX_TL));
      TG_GL: flat_val = clamp_level(wr_val, priv_only ? XLEN'(MAX_PGL) : XLEN'(MAX_GL));
      TG_SINT_SET: begin
        flat_idx = 5'(TG_SOFTINT); flat_val = regs_q[TG_SOFTINT] | wr_val; flat_we = commit;
      end
      TG_SINT_CLR: begin
        flat_idx = 5'(TG_SOFTINT); flat_val = regs_q[TG_SOFTINT] & ~wr_val; flat_we = commit;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < N_FLAT; i++) begin : g_flat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= (i == int'(TG_HPSTATE)) ? HPSTATE_RST : '0;
      else if (flat_we && flat_idx == 5'(i)) regs_q[i] <= flat_val;
    end
  end

  logic [XLEN-1:0] ts_tpc, ts_tnpc, ts_tstate, ts_tt, ts_htstate;
  ctlreg_trapstack #(.MAX_TL(MAX_TL)) u_stack (
    .clk(clk), .rst_n(rst_n), .wr_en(trap_we), .wr_kind(acc.tgt), .level(tl_now),
    .wr_data(wr_val), .rd_tpc(ts_tpc), .rd_tnpc(ts_tnpc), .rd_tstate(ts_tstate),
    .rd_tt(ts_tt), .rd_htstate(ts_htstate)
  );

  // read selection
  logic [XLEN-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(acc.tgt) < N_FLAT) rd_mux = regs_q[acc.tgt[4:0]];
    case (acc.tgt)
      TG_HVER:    rd_mux = VERSION;
      TG_PC:      rd_mux = pstate[3] ? {32'b0, pc_in[31:0]} : pc_in;
      TG_TICK:    rd_mux = tick_val;
      TG_STICK:   rd_mux = stick_val;
      TG_TPC:     rd_mux = ts_tpc;
      TG_TNPC:    rd_mux = ts_tnpc;
      TG_TSTATE:  rd_mux = ts_tstate;
      TG_TT:      rd_mux = ts_tt;
      TG_HTSTATE: rd_mux = ts_htstate;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0; rsp_fault <= 3'd0;
      cnt_wr_en <= 1'b0; cnt_wr_stick <= 1'b0; cnt_wr_data <= '0;
    end else begin
      rsp_valid    <= op_valid;
      rsp_fault    <= op_valid ? fault_c : FLT_NONE;
      rsp_data     <= (op_valid && !op_write && fault_c == FLT_NONE) ? rd_mux : '0;
      cnt_wr_en    <= cnt_commit;
      cnt_wr_stick <= (acc.tgt == TG_STICK);
      cnt_wr_data  <= wr_val;
    end
  end

  // R6
  tl_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[TG_TL] <= XLEN'(MAX_TL));
  // R6
  gl_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[TG_GL] <= XLEN'(MAX_GL));
  // R6
  priv_tl_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_write && op_bank == 2'd1 && op_regno == 5'h07 && priv_only && fault_c == FLT_NONE)
    |=> regs_q[TG_TL] <= XLEN'(MAX_PTL));
  // R13
  rsp_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> rsp_valid);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!rsp_valid && rsp_fault == 3'd0));
  // R11
  fault_no_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 3'd0) |-> !cnt_wr_en);
  // R3
  hyp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_bank == 2'd2 && !hpstate[2]) |=> rsp_fault != 3'd0);
endmodule

// File: tb/ctlreg_unit_test.sv
module ctlreg_unit_test;
  localparam int NWIN = 8, MAX_TL = 6, MAX_PTL = 2, MAX_GL = 3, MAX_PGL = 2;
  localparam logic [1:0] ANC = 2'd0, PRV = 2'd1, HYP = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_write = 1'b0, imm_sel = 1'b0;
  logic [1:0] op_bank = 2'd0;
  logic [4:0] op_regno = 5'd0;
  logic [63:0] src_a = '0, src_b = '0, pc_in = '0, tick_val = '0, stick_val = '0;
  logic [12:0] imm13 = '0;
  logic rsp_valid, cnt_wr_en, cnt_wr_stick;
  logic [63:0] rsp_data, cnt_wr_data;
  logic [2:0] rsp_fault;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic g_valid, g_cen, g_cstick;
  logic [63:0] g_data, g_cdata;
  logic [2:0] g_fault;

  always #5 clk = ~clk;

  ctlreg_unit #(.NWIN(NWIN), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write), .op_bank(op_bank),
    .op_regno(op_regno), .src_a(src_a), .src_b(src_b), .imm_sel(imm_sel), .imm13(imm13),
    .pc_in(pc_in), .tick_val(tick_val), .stick_val(stick_val), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_stick(cnt_wr_stick), .cnt_wr_data(cnt_wr_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] bk, input logic wr, input logic [4:0] rn,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic isel = 1'b0, input logic [12:0] imm = 13'd0);
    op_valid = 1'b1; op_write = wr; op_bank = bk; op_regno = rn;
    src_a = a; src_b = b; imm_sel = isel; imm13 = imm;
    @(posedge clk); #2;
    g_valid = rsp_valid; g_data = rsp_data; g_fault = rsp_fault;
    g_cen = cnt_wr_en; g_cstick = cnt_wr_stick; g_cdata = cnt_wr_data;
    op_valid = 1'b0; op_write = 1'b0; imm_sel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] bk, input logic [4:0] rn, input logic [63:0] v);
    issue(bk, 1'b1, rn, v, 64'd0);
  endtask

  task automatic rd(input logic [1:0] bk, input logic [4:0] rn);
    issue(bk, 1'b0, rn, 64'd0, 64'd0);
  endtask

  task automatic t_reset;
    check("R13 idle rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    rd(HYP, 5'h00);
    check("R13 rsp_valid", {63'd0, g_valid}, 64'd1);
    check("R3 hyper-state reset value", g_data, 64'd4);
    check("R3 hyper-state read fault", {61'd0, g_fault}, 64'd0);
    @(posedge clk); #2;
    check("R13 idle after op", {60'd0, rsp_fault, rsp_valid}, 64'd0);
  endtask

  task automatic t_operand;
    logic [63:0] a, b;
    a = 64'h0123_4567_89AB_CDEF; b = 64'hFFFF_0000_FFFF_0000;
    issue(ANC, 1'b1, 5'h00, a, b);
    check("R13 write returns zero data", g_data, 64'd0);
    rd(ANC, 5'h00);
    check("R1 register xor", g_data, a ^ b);
    issue(ANC, 1'b1, 5'h00, 64'h00FF, 64'h1234, 1'b1, 13'h1FF0);
    rd(ANC, 5'h00);
    check("R1 negative immediate", g_data, 64'h00FF ^ 64'hFFFF_FFFF_FFFF_FFF0);
    issue(ANC, 1'b1, 5'h00, 64'h00FF, 64'h1234, 1'b1, 13'h0123);
    rd(ANC, 5'h00);
    check("R1 positive immediate", g_data, 64'h00FF ^ 64'h0123);
  endtask

  task automatic t_version;
    rd(HYP, 5'h06);
    check("R9 version", g_data, 64'(NWIN) | (64'(MAX_TL) << 8) | (64'(MAX_GL) << 16));
    wr(HYP, 5'h06, 64'h1);
    check("R5 version write", {61'd0, g_fault}, 64'd1);
  endtask

  task automatic t_unassigned;
    rd(PRV, 5'h0F); check("R5 priv 0x0F", {61'd0, g_fault}, 64'd1);
    rd(PRV, 5'h11); check("R5 priv 0x11", {61'd0, g_fault}, 64'd1);
    rd(ANC, 5'h14); check("R5 anc read 0x14", {61'd0, g_fault}, 64'd1);
    rd(ANC, 5'h09); check("R5 anc 0x09", {61'd0, g_fault}, 64'd1);
    wr(ANC, 5'h05, 64'h1); check("R5 anc write 0x05", {61'd0, g_fault}, 64'd1);
    rd(HYP, 5'h02); check("R5 hyper 0x02", {61'd0, g_fault}, 64'd1);
    rd(2'd3, 5'h00); check("R5 reserved bank", {61'd0, g_fault}, 64'd1);
    check("R13 fault returns zero data", g_data, 64'd0);
  endtask

  task automatic t_tl_zero;
    rd(PRV, 5'h00); check("R4 trap pc at level 0", {61'd0, g_fault}, 64'd1);
    wr(PRV, 5'h03, 64'h5); check("R4 trap type write at level 0", {61'd0, g_fault}, 64'd1);
    rd(HYP, 5'h01); check("R4 hyper trap state at level 0", {61'd0, g_fault}, 64'd1);
  endtask

  task automatic t_trap_stack;
    wr(PRV, 5'h07, 64'd1);
    wr(PRV, 5'h00, 64'h1111);
    wr(PRV, 5'h03, 64'h2A);
    wr(PRV, 5'h07, 64'd2);
    wr(PRV, 5'h00, 64'h2222);
    wr(HYP, 5'h01, 64'h77);
    check("R10 hyper trap state write fault", {61'd0, g_fault}, 64'd0);
    rd(PRV, 5'h00); check("R10 level 2 trap pc", g_data, 64'h2222);
    wr(PRV, 5'h07, 64'd1);
    rd(PRV, 5'h00); check("R10 level 1 trap pc", g_data, 64'h1111);
    rd(PRV, 5'h03); check("R10 level 1 trap type", g_data, 64'h2A);
    rd(HYP, 5'h01); check("R10 level 1 hyper trap state", g_data, 64'd0);
    wr(PRV, 5'h07, 64'd2);
    rd(HYP, 5'h01); check("R10 level 2 hyper trap state", g_data, 64'h77);
    wr(PRV, 5'h07, 64'd0);
  endtask

  task automatic t_fp_gate;
    wr(ANC, 5'h13, 64'hBEEF); check("R7 write with FP off", {61'd0, g_fault}, 64'd3);
    rd(ANC, 5'h13); check("R7 read with FP off", {61'd0, g_fault}, 64'd3);
    wr(ANC, 5'h06, 64'h4);
    rd(ANC, 5'h13); check("R7 only FP-state bit set", {61'd0, g_fault}, 64'd3);
    wr(PRV, 5'h06, 64'h10);
    rd(ANC, 5'h13);
    check("R7 enabled read fault", {61'd0, g_fault}, 64'd0);
    check("R11 blocked write left value", g_data, 64'd0);
    wr(ANC, 5'h13, 64'hBEEF);
    rd(ANC, 5'h13); check("R7 enabled read back", g_data, 64'hBEEF);
    wr(PRV, 5'h06, 64'h0);
  endtask

  task automatic t_softreset;
    wr(ANC, 5'h00, 64'h5A);
    wr(ANC, 5'h0F, 64'h99); check("R8 soft reset fault", {61'd0, g_fault}, 64'd4);
    rd(ANC, 5'h00); check("R8 no update on soft reset", g_data, 64'h5A);
    rd(ANC, 5'h0F);
    check("R8 barrier read fault", {61'd0, g_fault}, 64'd0);
    check("R8 barrier read data", g_data, 64'd0);
  endtask

  task automatic t_counter;
    wr(PRV, 5'h04, 64'h1000);
    check("R14 tick write strobe", {62'd0, g_cen, g_cstick}, 64'd2);
    check("R14 tick write data", g_cdata, 64'h1000);
    tick_val = 64'h8000_0000_0000_0042;
    rd(ANC, 5'h04);
    check("R14 tick read hyper", g_data, 64'h8000_0000_0000_0042);
    wr(ANC, 5'h18, 64'h77);
    check("R14 system tick strobe", {62'd0, g_cen, g_cstick}, 64'd3);
    stick_val = 64'h33;
    rd(ANC, 5'h18); check("R14 system tick read", g_data, 64'h33);
    rd(ANC, 5'h00); check("R14 no strobe on read", {63'd0, g_cen}, 64'd0);
  endtask

  task automatic t_clamp;
    wr(PRV, 5'h07, 64'd50); rd(PRV, 5'h07); check("R6 hyper level ceiling", g_data, 64'(MAX_TL));
    wr(PRV, 5'h10, 64'd9); rd(PRV, 5'h10); check("R6 hyper global ceiling", g_data, 64'(MAX_GL));
    wr(PRV, 5'h06, 64'h4);
    wr(HYP, 5'h00, 64'h0);
    wr(PRV, 5'h07, 64'd50); rd(PRV, 5'h07); check("R6 priv level ceiling", g_data, 64'(MAX_PTL));
    wr(PRV, 5'h10, 64'd9); rd(PRV, 5'h10); check("R6 priv global ceiling", g_data, 64'(MAX_PGL));
    wr(PRV, 5'h07, 64'd1); rd(PRV, 5'h07); check("R6 below ceiling", g_data, 64'd1);
    wr(PRV, 5'h07, 64'd0);
  endtask

  task automatic t_pc;
    pc_in = 64'hABCD_0000_1234_5678;
    wr(PRV, 5'h06, 64'hC);
    rd(ANC, 5'h05); check("R12 masked pc", g_data, 64'h1234_5678);
    wr(PRV, 5'h06, 64'h4);
    rd(ANC, 5'h05); check("R12 full pc", g_data, 64'hABCD_0000_1234_5678);
  endtask

  task automatic t_gates;
    rd(HYP, 5'h00); check("R3 privileged only hyper read", {61'd0, g_fault}, 64'd2);
    wr(PRV, 5'h05, 64'h4000); check("R2 privileged tba write", {61'd0, g_fault}, 64'd0);
    wr(PRV, 5'h04, 64'h1);
    check("R14 tick write needs hyper", {61'd0, g_fault}, 64'd2);
    check("R11 no strobe on fault", {63'd0, g_cen}, 64'd0);
    wr(PRV, 5'h06, 64'h0);
    wr(PRV, 5'h05, 64'h9); check("R2 user tba write", {61'd0, g_fault}, 64'd2);
    rd(PRV, 5'h07); check("R2 user level read", {61'd0, g_fault}, 64'd2);
    wr(ANC, 5'h10, 64'h1); check("R2 user performance control", {61'd0, g_fault}, 64'd2);
    rd(ANC, 5'h04); check("R14 user tick with trap bit", {61'd0, g_fault}, 64'd2);
    tick_val = 64'h42;
    rd(ANC, 5'h04); check("R14 user tick open", g_data, 64'h42);
    wr(ANC, 5'h18, 64'h1);
    check("R14 user system tick write", {61'd0, g_fault}, 64'd1);
    check("R11 no strobe on illegal", {63'd0, g_cen}, 64'd0);
    wr(ANC, 5'h00, 64'h3); check("R2 user Y write open", {61'd0, g_fault}, 64'd0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_operand();
    t_version();
    t_unassigned();
    t_tl_zero();
    t_trap_stack();
    t_fp_gate();
    t_softreset();
    t_counter();
    t_clamp();
    t_pc();
    t_gates();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule